// File: doc/BRIEF.md
# Edge Timestamp Capture Channel

This block timestamps transitions of an asynchronous input against a free-running timer count. The input is brought into the clock domain through a synchroniser chain, and its transitions are qualified by a programmable edge mode: rising only, falling only, either, or none. Each qualifying transition latches the timer value together with a count of timer wraps seen since the previous capture. Software can therefore measure a period or a pulse width that spans several timer periods without losing whole periods.

The timer value is delayed through a pipeline exactly as deep as the synchroniser. The stamp is therefore the count that was present when the input change was first sampled, not the count present when the change was recognised. The time base is either an internal counter that increments once per clock, or an external count with its own wrap marker, chosen at run time. A one-cycle strobe announces each new stamp. A sticky flag records that a stamp was overwritten before a reader acknowledged it.

Top module: `edge_stamp_capture`

## Requirements
- R1: A qualifying input change applied in cycle N raises `stamp_valid` in cycle N+SYNC_STAGES+1, with the default SYNC_STAGES of 2 giving 3 cycles.
- R2: `stamp_cnt` equals the value shown on `cnt_now` in the cycle in which `cap_in` changed.
- R3: `edge_sel` encodes the qualifying edges as 2'b01 rising, 2'b10 falling and 2'b11 both. With 2'b00, no change of `cap_in` produces a capture.
- R4: `stamp_ovf` is the number of timer wraps from the cycle after the previous stamped cycle up to and including the stamped cycle. A wrap in the same cycle as the edge is therefore counted in that stamp.
- R5: A wrap is the cycle in which the internal count shows 0 after showing its maximum, or, with `src_ext` high, any cycle with `ext_wrap` high.
- R6: The wrap count saturates at 2^OVF_W-1 and does not roll over.
- R7: A capture while an earlier stamp is unacknowledged sets the sticky `overcap` flag and still replaces the stamp. A high `cap_ack` clears `overcap` and the unread state from the next cycle on, and a capture in the same cycle as `cap_ack` does not set `overcap`.
- R8: With `src_ext` low, `cnt_now` is an internal count that starts at 0 after reset and rises by one every cycle, wrapping at 2^CNT_W-1. With `src_ext` high, `cnt_now` follows `ext_cnt`.
- R9: After reset, `stamp_valid`, `overcap`, `stamp_cnt`, `stamp_ovf` and `cnt_now` are all 0.
- R10: `stamp_valid` is high for exactly one cycle per capture and is never high without a qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_in | input | 1 | Asynchronous input to be timestamped |
| edge_sel | input | 2 | Qualifying edge mode |
| src_ext | input | 1 | Select the external time base when high |
| ext_cnt | input | CNT_W | External count value |
| ext_wrap | input | 1 | External wrap marker, aligned with ext_cnt |
| cap_ack | input | 1 | Reader acknowledge of the current stamp |
| cnt_now | output | CNT_W | Selected time-base value this cycle |
| stamp_cnt | output | CNT_W | Latched count of the last capture |
| stamp_ovf | output | OVF_W | Wraps since the previous capture |
| stamp_valid | output | 1 | One-cycle new-stamp strobe |
| overcap | output | 1 | Sticky overwritten-before-read flag |

## Verification
The bench targets latency compensation first. A design that stamped the count at recognition time would report values two counts too high. It also places an edge in the same cycle as a wrap marker: a design that reset the wrap count before adding that wrap would report one period short. Captured intervals are made longer than the timer period, and the wrap counter is driven past its maximum, which would expose a counter that rolls over or forgets wraps. The overwrite and acknowledge sequences check that the flag is sticky, that the newest stamp wins, and that a disabled edge mode produces no strobe at all.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic [1:0] {
        EM_OFF  = 2'b00,
        EM_RISE = 2'b01,
        EM_FALL = 2'b10,
        EM_ANY  = 2'b11
    } edge_mode_e;
endpackage

// File: rtl/esc_sync_edge.sv
module esc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       raw_in,
    input  logic [1:0] mode,
    output logic       hit
);
    import esc_pkg::*;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              last;
    } st_t;

    st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[STAGES-2:0], raw_in};
        st_d.last  = st_q.chain[STAGES-1];
        rise = st_q.chain[STAGES-1] & ~st_q.last;
        fall = ~st_q.chain[STAGES-1] & st_q.last;
        unique case (edge_mode_e'(mode))
            EM_RISE: hit = rise;
            EM_FALL: hit = fall;
            EM_ANY:  hit = rise | fall;
            default: hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a disabled mode never yields a capture
    a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> !hit);
endmodule

// File: rtl/esc_timebase.sv
module esc_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_ext,
    input  logic [CNT_W-1:0] ext_cnt,
    input  logic             ext_wrap,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             wrap;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cnt  = st_q.cnt + 1'b1;
        st_d.wrap = (st_q.cnt == CNT_MAX);
        cnt  = src_ext ? ext_cnt  : st_q.cnt;
        wrap = src_ext ? ext_wrap : st_q.wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8: the internal count advances by one every cycle
    a_r8_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CNT_MAX) |=> (st_q.cnt == CNT_W'($past(st_q.cnt) + 1'b1)));
    // R5: the internal wrap marker only accompanies a zero count
    a_r5_wrap_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wrap |-> (st_q.cnt == '0));
endmodule

// File: rtl/esc_delay_pipe.sv
module esc_delay_pipe #(
    parameter int W     = 17,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stg;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < DEPTH; i++) st_d.stg[i] = st_q.stg[i-1];
        dout = st_q.stg[DEPTH-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/esc_capture_reg.sv
module esc_capture_reg #(
    parameter int CNT_W = 16,
    parameter int OVF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [CNT_W-1:0] cnt_dly,
    input  logic             wrap_dly,
    input  logic             ack,
    output logic [CNT_W-1:0] stamp_cnt,
    output logic [OVF_W-1:0] stamp_ovf,
    output logic             valid,
    output logic             overcap
);
    localparam logic [OVF_W-1:0] OVF_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] stamp_cnt;
        logic [OVF_W-1:0] stamp_ovf;
        logic [OVF_W-1:0] acc;
        logic             valid;
        logic             pending;
        logic             overcap;
    } st_t;

    st_t st_d, st_q;
    logic [OVF_W-1:0] acc_next;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        // wraps of this cycle are counted before any stamp is taken
        acc_next = (wrap_dly && st_q.acc != OVF_MAX) ? st_q.acc + 1'b1 : st_q.acc;
        if (hit) begin
            st_d.stamp_cnt = cnt_dly;
            st_d.stamp_ovf = acc_next;
            st_d.acc       = '0;
            st_d.valid     = 1'b1;
            st_d.pending   = 1'b1;
            if (st_q.pending && !ack) st_d.overcap = 1'b1;
        end else begin
            st_d.acc = acc_next;
        end
        if (ack) begin
            st_d.overcap = 1'b0;
            if (!hit) st_d.pending = 1'b0;
        end
        stamp_cnt = st_q.stamp_cnt;
        stamp_ovf = st_q.stamp_ovf;
        valid     = st_q.valid;
        overcap   = st_q.overcap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: overwrite of an unread stamp raises the flag
    a_r7_overcap_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && st_q.pending && !ack) |=> st_q.overcap);
    // R7: flag holds until acknowledged
    a_r7_overcap_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.overcap && !ack) |=> st_q.overcap);
    // R6: a full wrap count never rolls over between captures
    a_r6_acc_holds_max: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc == OVF_MAX && !hit) |=> (st_q.acc == OVF_MAX));
    // R1: every recognised edge produces a strobe on the next cycle
    a_r1_strobe_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> st_q.valid);
endmodule

// File: rtl/edge_stamp_capture.sv
module edge_stamp_capture #(
    parameter int CNT_W       = 16,
    parameter int OVF_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap_in,
    input  logic [1:0]       edge_sel,
    input  logic             src_ext,
    input  logic [CNT_W-1:0] ext_cnt,
    input  logic             ext_wrap,
    input  logic             cap_ack,
    output logic [CNT_W-1:0] cnt_now,
    output logic [CNT_W-1:0] stamp_cnt,
    output logic [OVF_W-1:0] stamp_ovf,
    output logic             stamp_valid,
    output logic             overcap
);
    localparam int PIPE_W = CNT_W + 1;

    logic             tb_wrap;
    logic             edge_hit;
    logic [PIPE_W-1:0] dly_bus;

    esc_timebase #(.CNT_W(CNT_W)) u_timebase (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_ext  (src_ext),
        .ext_cnt  (ext_cnt),
        .ext_wrap (ext_wrap),
        .cnt      (cnt_now),
        .wrap     (tb_wrap)
    );

    esc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_in (cap_in),
        .mode   (edge_sel),
        .hit    (edge_hit)
    );

    // the count travels alongside the synchroniser so the stamp is compensated
    esc_delay_pipe #(.W(PIPE_W), .DEPTH(SYNC_STAGES)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({tb_wrap, cnt_now}),
        .dout  (dly_bus)
    );

    esc_capture_reg #(.CNT_W(CNT_W), .OVF_W(OVF_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (edge_hit),
        .cnt_dly   (dly_bus[CNT_W-1:0]),
        .wrap_dly  (dly_bus[CNT_W]),
        .ack       (cap_ack),
        .stamp_cnt (stamp_cnt),
        .stamp_ovf (stamp_ovf),
        .valid     (stamp_valid),
        .overcap   (overcap)
    );
endmodule

// File: tb/edge_stamp_capture_tb.sv
module edge_stamp_capture_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 8;
    localparam int OVF_W = 4;
    localparam int SYNC  = 2;
    localparam int LAT   = SYNC + 1;
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam logic [OVF_W-1:0] OMAX = '1;

    logic clk = 0, rst_n = 0;
    logic cap_in = 0, src_ext = 0, ext_wrap = 0, cap_ack = 0;
    logic [1:0] edge_sel = 2'b01;
    logic [CNT_W-1:0] ext_cnt = '0;
    logic [CNT_W-1:0] cnt_now, stamp_cnt;
    logic [OVF_W-1:0] stamp_ovf;
    logic stamp_valid, overcap;

    edge_stamp_capture #(.CNT_W(CNT_W), .OVF_W(OVF_W), .SYNC_STAGES(SYNC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(edge_sel),
        .src_ext(src_ext), .ext_cnt(ext_cnt), .ext_wrap(ext_wrap), .cap_ack(cap_ack),
        .cnt_now(cnt_now), .stamp_cnt(stamp_cnt), .stamp_ovf(stamp_ovf),
        .stamp_valid(stamp_valid), .overcap(overcap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic last_cap = 0;
    logic [CNT_W-1:0] prev_int = '0;
    logic [OVF_W-1:0] acc = '0;
    bit               exp_live [4];
    int               exp_due  [4];
    logic [CNT_W-1:0] exp_cnt  [4];
    logic [OVF_W-1:0] exp_ovf  [4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // one cycle: check outputs due now, then drive inputs and update the model
    task automatic step(input logic cap, input logic ack, input logic [CNT_W-1:0] ecnt,
                        input logic ewrap);
        int s;
        logic [CNT_W-1:0] cur;
        logic wr;
        logic [OVF_W-1:0] acc_w;
        bit qual;
        @(negedge clk);
        cyc++;
        s = cyc % 4;
        if (exp_live[s] && exp_due[s] == cyc) begin
            chk(stamp_valid == 1'b1, "R1 strobe latency", int'(stamp_valid), 1);
            chk(stamp_cnt == exp_cnt[s], "R2 compensated stamp", int'(stamp_cnt), int'(exp_cnt[s]));
            chk(stamp_ovf == exp_ovf[s], "R4 wrap count", int'(stamp_ovf), int'(exp_ovf[s]));
            exp_live[s] = 0;
        end else begin
            chk(stamp_valid == 1'b0, "R10 no spurious strobe", int'(stamp_valid), 0);
        end
        cap_in = cap; cap_ack = ack; ext_cnt = ecnt; ext_wrap = ewrap;
        cur = src_ext ? ecnt : cnt_now;
        wr  = src_ext ? ewrap : (cnt_now == '0 && prev_int == CMAX);
        prev_int = cnt_now;
        acc_w = (wr && acc != OMAX) ? acc + 1'b1 : acc;
        qual = (edge_sel[0] && cap && !last_cap) || (edge_sel[1] && !cap && last_cap);
        if (qual) begin
            s = (cyc + LAT) % 4;
            exp_live[s] = 1; exp_due[s] = cyc + LAT;
            exp_cnt[s] = cur; exp_ovf[s] = acc_w;
            acc = '0;
        end else begin
            acc = acc_w;
        end
        last_cap = cap;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(last_cap, 1'b0, ext_cnt, 1'b0);
    endtask

    task automatic t_reset;
        chk(stamp_valid == 0, "R9 reset valid", int'(stamp_valid), 0);
        chk(overcap == 0, "R9 reset overcap", int'(overcap), 0);
        chk(stamp_cnt == 0, "R9 reset stamp", int'(stamp_cnt), 0);
        chk(stamp_ovf == 0, "R9 reset ovf", int'(stamp_ovf), 0);
        chk(cnt_now == 0, "R9 reset count", int'(cnt_now), 0);
    endtask

    task automatic t_count;
        logic [CNT_W-1:0] a;
        step(0, 0, '0, 0); a = cnt_now;
        step(0, 0, '0, 0);
        chk(cnt_now == CNT_W'(a + 1), "R8 internal increment", int'(cnt_now), int'(CNT_W'(a + 1)));
    endtask

    task automatic t_rise;
        edge_sel = 2'b01;
        step(1, 0, '0, 0); idle(6);
        step(0, 0, '0, 0); idle(6);   // falling edge ignored (R3)
        step(1, 0, '0, 0); idle(9);
        step(0, 0, '0, 0); idle(6);
    endtask

    task automatic t_fall;
        edge_sel = 2'b10;
        step(1, 0, '0, 0); idle(6);   // rising edge ignored (R3)
        step(0, 0, '0, 0); idle(6);
    endtask

    task automatic t_both;
        edge_sel = 2'b11;
        step(1, 0, '0, 0); step(1, 0, '0, 0);
        step(0, 0, '0, 0); idle(3);
        step(1, 0, '0, 0); step(0, 0, '0, 0); idle(6);
    endtask

    task automatic t_off;
        edge_sel = 2'b00;
        for (int i = 0; i < 6; i++) step(~last_cap, 0, '0, 0);
        idle(6);
        chk(stamp_valid == 0, "R3 disabled mode", int'(stamp_valid), 0);
        if (last_cap) begin step(0, 0, '0, 0); idle(4); end
    endtask

    task automatic t_long_period;
        edge_sel = 2'b01;
        step(1, 0, '0, 0); idle(3); step(0, 0, '0, 0); idle(300);
        step(1, 0, '0, 0); idle(3); step(0, 0, '0, 0); idle(560);
        step(1, 0, '0, 0); idle(3); step(0, 0, '0, 0); idle(6);
    endtask

    task automatic t_overcap;
        edge_sel = 2'b01;
        step(0, 1, '0, 0); idle(2);
        chk(overcap == 0, "R7 cleared by ack", int'(overcap), 0);
        step(1, 0, '0, 0); idle(3); step(0, 0, '0, 0); idle(3);
        chk(overcap == 0, "R7 single capture", int'(overcap), 0);
        step(1, 0, '0, 0); idle(2);
        step(1, 0, '0, 0);            // due cycle of the overwrite
        chk(overcap == 1, "R7 overwrite sets flag", int'(overcap), 1);
        step(0, 0, '0, 0); idle(8);
        chk(overcap == 1, "R7 flag sticky", int'(overcap), 1);
        step(0, 1, '0, 0); step(0, 0, '0, 0);
        chk(overcap == 0, "R7 ack clears", int'(overcap), 0);
        step(1, 0, '0, 0); idle(6);
        chk(overcap == 0, "R7 first capture after ack", int'(overcap), 0);
        step(0, 0, '0, 0); idle(4);
    endtask

    task automatic t_external;
        src_ext = 1; edge_sel = 2'b01;
        step(0, 1, 8'd200, 0); idle(2);
        chk(cnt_now == 8'd200, "R8 external count", int'(cnt_now), 200);
        step(1, 0, 8'd17, 0); idle(4);           // flush the wrap count
        step(0, 0, 8'd40, 1); step(0, 0, 8'd41, 0);
        step(1, 0, 8'd0, 1);                     // edge and wrap in one cycle (R4, R5)
        idle(5);
        step(0, 0, 8'd90, 0); idle(3);
    endtask

    task automatic t_saturate;
        src_ext = 1; edge_sel = 2'b01;
        for (int i = 0; i < 20; i++) step(0, 0, CNT_W'(i), 1);   // R6 beyond maximum
        step(1, 0, 8'd123, 0); idle(5);
        chk(stamp_ovf == OMAX, "R6 saturated wrap count", int'(stamp_ovf), int'(OMAX));
        step(0, 0, 8'd5, 0); idle(3);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) exp_live[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_count();
        t_rise();
        t_fall();
        t_both();
        t_off();
        t_long_period();
        t_overcap();
        t_external();
        t_saturate();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule